// File: doc/BRIEF.md
# Dual Peripheral Pin Port Register Bank

This block gives a host processor byte-wide register access to two 7-pin peripheral connectors. Each connector has a value register and a direction register. A direction bit set to 1 drives that pin from the matching value bit. A direction bit of 0 leaves the pin as an input, and reading the value register then returns the pin's level after it passes a two-stage synchronizer. The top bit of each 8-bit register has no pin behind it. It still keeps and returns whatever was last written to it.

A shared ownership register decides, per connector, whether an automatic poller outside this block should service the connector or leave it to the host. The block turns that register into one poll-enable line per connector for the poller. An ownership bit never blocks host reads or writes. The pins themselves are pulled high on the board, so an idle connector with all pins as inputs reads back 0x7F.

Pin order inside each 7-bit field, from bit 6 down to bit 0, is select, toggle, acknowledge, then data nibble bits 3 to 0. The register map is: address 0 is the port A value, 1 the port B value, 2 the port A direction, 3 the port B direction and 4 the ownership register.

Top module: `pad_port_regs`

## Requirements
- R1: After a synchronous active-low reset, all direction and value registers and the ownership register read 0, `pin_oe` is all zero, and `poll_en` is all ones.
- R2: For each port, `pin_oe` carries direction bits 6..0 and `pin_out` carries value bits 6..0. Port A occupies pin bits 6..0 and port B occupies pin bits 13..7.
- R3: Reading a value register returns, in each bit 6..0, the stored value bit where the direction bit is 1 and the synchronized pin level where it is 0.
- R4: Bit 7 of every value and direction register stores the written bit and reads it back, with no effect on any pin output or enable.
- R5: With every pin held high and all directions 0, each value register reads 0x7F.
- R6: Ownership bit 0 governs port A and bit 1 governs port B. A 0 raises that port's `poll_en` bit and a 1 clears it, one clock after the write.
- R7: Host writes and reads of value and direction registers work the same whatever the ownership bits hold.
- R8: Ownership bits 7..2 store the written value and read it back.
- R9: A pin change becomes visible on readback exactly two rising clock edges after it is sampled, and not after one.
- R10: Addresses 0 to 4 decode as listed above. Any other address reads 0, and writes to it change no register. No register changes without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 14 | Sampled pin levels, port B in bits 13..7 |
| pin_out | output | 14 | Pin drive values |
| pin_oe | output | 14 | Pin output enables |
| poll_en | output | 2 | Per-port permission for the external poller |

## Verification
The readback mix is exercised with several direction patterns:
- all inputs;
- a pattern with the top two pins as outputs;
- a sparse pattern on port B.

Each is paired with pin levels that differ from the stored values. A wrong bit therefore shows whether it came from the register or from the pin. Bit 7 is written as 1 on both register kinds to tell storage apart from pin function. Ownership values with high unused bits separate storage from the poll-enable decode. A single pin edge, checked after one edge and again after two, pins down the synchronizer depth. A write to an unmapped address, followed by reads of its neighbours, shows decode leakage.

// File: rtl/pad_port_pkg.sv
// Shared definitions for the dual pin port register bank.
// Assumes the register map: value regs, then direction regs, then ownership.
package pad_port_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        KIND_VALUE = 2'd0,
        KIND_DIR   = 2'd1,
        KIND_OWN   = 2'd2,
        KIND_NONE  = 2'd3
    } reg_kind_e;

    // Classify an address into a register kind for a given port count.
    function automatic reg_kind_e classify(input int unsigned addr, input int unsigned ports);
        if (addr < ports)           return KIND_VALUE;
        else if (addr < 2 * ports)  return KIND_DIR;
        else if (addr == 2 * ports) return KIND_OWN;
        else                        return KIND_NONE;
    endfunction

    // Port index addressed within a value or direction group.
    function automatic int unsigned port_of(input int unsigned addr, input int unsigned ports);
        if (addr < ports) return addr;
        else              return addr - ports;
    endfunction

endpackage

// File: rtl/pps_sync.sv
// Multi-stage input synchronizer for a bus of independent pin levels.
// Assumes each bit is unrelated to the others (no bus coherency needed).
// Resets to RST_VAL so an idle, pulled-up pin reads high from reset on.
module pps_sync #(
    parameter int   W       = 7,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    // Shift the sampled pin levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= {W{RST_VAL}};
            end
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pps_lane.sv
// One peripheral port: value and direction registers plus per-bit readback.
// Assumes pin_sync is already synchronized to clk. The top register bit has
// no pin and only stores the written value.
module pps_lane #(
    parameter int PIN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             value_we,
    input  logic             dir_we,
    input  logic [PIN_W:0]   wdata,
    input  logic [PIN_W-1:0] pin_sync,
    output logic [PIN_W:0]   value_rd,
    output logic [PIN_W:0]   dir_rd,
    output logic [PIN_W-1:0] pin_out,
    output logic [PIN_W-1:0] pin_oe
);

    logic [PIN_W:0] value_q;
    logic [PIN_W:0] dir_q;

    // Hold the host-written value and direction bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
            dir_q   <= '0;
        end else begin
            if (value_we) value_q <= wdata;
            if (dir_we)   dir_q   <= wdata;
        end
    end

    // Per pin: driven bits read the stored value, input bits read the pin.
    for (genvar b = 0; b < PIN_W; b++) begin : g_bit
        assign value_rd[b] = dir_q[b] ? value_q[b] : pin_sync[b];
    end
    assign value_rd[PIN_W] = value_q[PIN_W];

    assign dir_rd  = dir_q;
    assign pin_out = value_q[PIN_W-1:0];
    assign pin_oe  = dir_q[PIN_W-1:0];

endmodule

// File: rtl/pps_owner.sv
// Ownership register: one bit per port hands it to the host (1) or leaves
// it to the external poller (0). Remaining bits are plain storage.
// Assumes NUM_PORTS <= REG_W.
module pps_owner #(
    parameter int REG_W     = 8,
    parameter int NUM_PORTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [REG_W-1:0]     wdata,
    output logic [REG_W-1:0]     rd,
    output logic [NUM_PORTS-1:0] poll_en
);

    logic [REG_W-1:0] own_q;

    // Store the full ownership byte, unused bits included.
    always_ff @(posedge clk) begin
        if (!rst_n)  own_q <= '0;
        else if (we) own_q <= wdata;
    end

    // The poller may service a port while its ownership bit is clear.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_poll
        assign poll_en[p] = ~own_q[p];
    end

    assign rd = own_q;

endmodule

// File: rtl/pad_port_regs.sv
// Register bank for NUM_PORTS bidirectional pin ports with a byte bus.
// Assumes one access per cycle, combinational read data, and board-level
// pull-ups on every pin. Port p owns pin bits [p*PIN_W +: PIN_W].
module pad_port_regs
    import pad_port_pkg::*;
#(
    parameter int NUM_PORTS   = 2,
    parameter int PIN_W       = 7,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_we,
    input  logic [PIN_W:0]             bus_wdata,
    output logic [PIN_W:0]             bus_rdata,
    input  logic [NUM_PORTS*PIN_W-1:0] pin_in,
    output logic [NUM_PORTS*PIN_W-1:0] pin_out,
    output logic [NUM_PORTS*PIN_W-1:0] pin_oe,
    output logic [NUM_PORTS-1:0]       poll_en
);

    localparam int REG_W = PIN_W + 1;
    localparam int ALL_W = NUM_PORTS * PIN_W;

    reg_kind_e          acc_kind;
    int unsigned        acc_port;
    logic [NUM_PORTS-1:0] value_we;
    logic [NUM_PORTS-1:0] dir_we;
    logic               own_we;
    logic [ALL_W-1:0]   pin_sync;
    logic [REG_W-1:0]   lane_value_rd [NUM_PORTS];
    logic [REG_W-1:0]   lane_dir_rd   [NUM_PORTS];
    logic [REG_W-1:0]   own_rd;

    // Decode the bus address into register kind and port index.
    always_comb begin
        acc_kind = classify(int'(bus_addr), NUM_PORTS);
        acc_port = port_of(int'(bus_addr), NUM_PORTS);
    end

    // Turn the decoded access into per-register write strobes.
    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            value_we[p] = bus_we && (acc_kind == KIND_VALUE) && (acc_port == p);
            dir_we[p]   = bus_we && (acc_kind == KIND_DIR)   && (acc_port == p);
        end
        own_we = bus_we && (acc_kind == KIND_OWN);
    end

    pps_sync #(
        .W       (ALL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) pin_sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        pps_lane #(
            .PIN_W (PIN_W)
        ) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .value_we (value_we[p]),
            .dir_we   (dir_we[p]),
            .wdata    (bus_wdata),
            .pin_sync (pin_sync[p*PIN_W +: PIN_W]),
            .value_rd (lane_value_rd[p]),
            .dir_rd   (lane_dir_rd[p]),
            .pin_out  (pin_out[p*PIN_W +: PIN_W]),
            .pin_oe   (pin_oe[p*PIN_W +: PIN_W])
        );
    end

    pps_owner #(
        .REG_W     (REG_W),
        .NUM_PORTS (NUM_PORTS)
    ) owner_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (own_we),
        .wdata   (bus_wdata),
        .rd      (own_rd),
        .poll_en (poll_en)
    );

    // Select read data for the addressed register; unmapped reads give 0.
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (acc_kind == KIND_VALUE && acc_port == p) bus_rdata = lane_value_rd[p];
            if (acc_kind == KIND_DIR   && acc_port == p) bus_rdata = lane_dir_rd[p];
        end
        if (acc_kind == KIND_OWN) bus_rdata = own_rd;
    end

endmodule

// File: rtl/pad_port_regs_chk.sv
// Property checker for pad_port_regs, attached by bind below.
// Assumes the default two-stage synchronizer for the latency property.
module pad_port_regs_chk #(
    parameter int NUM_PORTS = 2,
    parameter int PIN_W     = 7,
    parameter int ADDR_W    = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic                       bus_we,
    input logic [PIN_W:0]             bus_wdata,
    input logic [PIN_W:0]             bus_rdata,
    input logic [NUM_PORTS*PIN_W-1:0] pin_in,
    input logic [NUM_PORTS*PIN_W-1:0] pin_out,
    input logic [NUM_PORTS*PIN_W-1:0] pin_oe,
    input logic [NUM_PORTS-1:0]       poll_en
);

    localparam logic [ADDR_W-1:0] OWN_ADDR  = ADDR_W'(2 * NUM_PORTS);
    localparam logic [ADDR_W-1:0] DIR0_ADDR = ADDR_W'(NUM_PORTS);

    logic [1:0] since_rst;

    // Count clock edges since reset release, saturating at 2.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 2) since_rst <= since_rst + 2'd1;
    end

    // R2
    oe_follows_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == DIR0_ADDR) |=> (pin_oe[PIN_W-1:0] == $past(bus_wdata[PIN_W-1:0])));

    // R4
    dir_byte_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == DIR0_ADDR) |=> (bus_addr != DIR0_ADDR || bus_rdata == $past(bus_wdata)));

    // R6
    poll_follows_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OWN_ADDR) |=> (poll_en == ~$past(bus_wdata[NUM_PORTS-1:0])));

    // R10
    outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pin_oe) && $stable(pin_out) && $stable(poll_en)));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
        // R3
        driven_bits_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_addr == ADDR_W'(p)) |->
            (((bus_rdata[PIN_W-1:0] ^ pin_out[p*PIN_W +: PIN_W]) & pin_oe[p*PIN_W +: PIN_W]) == '0));

        // R9
        input_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == 2 && bus_addr == ADDR_W'(p)) |->
            (((bus_rdata[PIN_W-1:0] ^ $past(pin_in[p*PIN_W +: PIN_W], 2)) & ~pin_oe[p*PIN_W +: PIN_W]) == '0));
    end

endmodule

bind pad_port_regs pad_port_regs_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PIN_W     (PIN_W),
    .ADDR_W    (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .poll_en   (poll_en)
);

// File: tb/pad_port_regs_tb_top.sv
// Bench: a vector table walked by one loop, then directed tests.
module pad_port_regs_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [13:0] pin_in = 14'h3FFF;
    logic [13:0] pin_out;
    logic [13:0] pin_oe;
    logic [1:0]  poll_en;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pad_port_regs dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .poll_en   (poll_en)
    );

    typedef struct packed {
        logic        we;
        logic [2:0]  waddr;
        logic [7:0]  wdata;
        logic [13:0] pins;
        logic [2:0]  raddr;
        logic [7:0]  exp;
        logic [3:0]  req;
    } vec_t;

    // Pins are {port B, port A}; addresses: 0/1 value A/B, 2/3 dir A/B, 4 owner.
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd0, 8'h00, 14'h3FFF, 3'd0, 8'h7F, 4'd5},  // R5 idle port A
        '{1'b0, 3'd0, 8'h00, 14'h3FFF, 3'd1, 8'h7F, 4'd5},  // R5 idle port B
        '{1'b1, 3'd2, 8'h60, 14'h3F8A, 3'd0, 8'h0A, 4'd3},  // R3 two outputs low
        '{1'b1, 3'd0, 8'h40, 14'h3F8A, 3'd0, 8'h4A, 4'd3},  // R3 mixed drive
        '{1'b1, 3'd0, 8'hFF, 14'h3F80, 3'd0, 8'hE0, 4'd4},  // R4 bit 7 value
        '{1'b1, 3'd3, 8'h85, 14'h3F80, 3'd3, 8'h85, 4'd4},  // R4 bit 7 dir
        '{1'b1, 3'd1, 8'h7F, 14'h0000, 3'd1, 8'h05, 4'd3},  // R3 sparse on B
        '{1'b1, 3'd4, 8'hF3, 14'h3FFF, 3'd4, 8'hF3, 4'd8},  // R8 owner storage
        '{1'b1, 3'd0, 8'h15, 14'h3FFF, 3'd0, 8'h1F, 4'd7},  // R7 host owns A
        '{1'b1, 3'd5, 8'hAA, 14'h3FFF, 3'd5, 8'h00, 4'd10}, // R10 unmapped
        '{1'b0, 3'd0, 8'h00, 14'h3FFF, 3'd2, 8'h60, 4'd10}  // R10 no leakage
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, {24'h0, bus_rdata}, {24'h0, exp});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        chk("R1", {18'h0, pin_oe}, 32'h0);
        chk("R1", {30'h0, poll_en}, 32'h3);
        read_chk("R1", 3'd2, 8'h00);
        read_chk("R1", 3'd4, 8'h00);

        // Vector table.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            pin_in    = VECS[i].pins;
            bus_addr  = VECS[i].waddr;
            bus_wdata = VECS[i].wdata;
            bus_we    = VECS[i].we;
            @(posedge clk);
            @(negedge clk);
            bus_we = 1'b0;
            @(posedge clk);
            @(posedge clk);
            read_chk($sformatf("R%0d", VECS[i].req), VECS[i].raddr, VECS[i].exp);
        end

        // R2 pin drive follows registers (A: dir 60 val 15, B: dir 85 val 7F).
        chk("R2", {25'h0, pin_oe[6:0]},   32'h60);
        chk("R2", {25'h0, pin_out[6:0]},  32'h15);
        chk("R2", {25'h0, pin_oe[13:7]},  32'h05);
        chk("R2", {25'h0, pin_out[13:7]}, 32'h7F);

        // R9 synchronizer depth: drop pin A bit 0 (an input).
        @(negedge clk);
        bus_addr = 3'd0;
        pin_in   = 14'h3FFE;
        @(posedge clk);
        @(negedge clk);
        #1;
        chk("R9", {24'h0, bus_rdata}, 32'h1F);
        @(posedge clk);
        @(negedge clk);
        #1;
        chk("R9", {24'h0, bus_rdata}, 32'h1E);

        // R6 ownership bit to port mapping.
        chk("R6", {30'h0, poll_en}, 32'h0);
        bus_write(3'd4, 8'h01);
        chk("R6", {30'h0, poll_en}, 32'h2);
        bus_write(3'd4, 8'h02);
        chk("R6", {30'h0, poll_en}, 32'h1);
        bus_write(3'd4, 8'h00);
        chk("R6", {30'h0, poll_en}, 32'h3);

        // R1 second reset after activity.
        @(negedge clk);
        pin_in = 14'h3FFF;
        rst_n  = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", {18'h0, pin_oe}, 32'h0);
        chk("R1", {18'h0, pin_out}, 32'h0);
        read_chk("R1", 3'd3, 8'h00);
        read_chk("R1", 3'd0, 8'h7F);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule